// File: doc/BRIEF.md
# Periodic Forced Write-Back Scanner

This controller sits beside a small write-back cache of `LINES` lines. Next to each line's dirty flag it keeps a second "force" flag. At a programmable interval it walks every line index in ascending order. A dirty line that carries no force flag is only marked during that walk. A line that is still both marked and dirty when a later walk reaches it is handed to the memory side as a write-back request. Because of this two-walk rule, no modified line stays only in the cache for longer than about two scan intervals. The interval is chosen from the size of the persistent log ring and the write bandwidth of the nonvolatile memory, so that data always reaches memory before the ring wraps over the entries that describe it.

The cache reports stores and evictions to the block. The block issues write-backs one line at a time, and each one waits for an acknowledge. A context-switch request is held until no write-back is outstanding. Transaction boundaries play no part in the block's operation.

Top module: `fwb_scanner`

## Requirements
- R1: After reset all dirty and force flags are 0, `wb_req_o` is 0 and `cs_grant_o` is 0.
- R2: A store notification sets that line's dirty flag. When a walk reaches a dirty line whose force flag is 0, it sets the force flag and issues no write-back for that line in that walk.
- R3: When a walk reaches a line whose dirty and force flags are both 1, `wb_req_o` rises with `wb_line_o` equal to that line's index.
- R4: An eviction notification clears both the dirty and the force flag of that line. A line cleared this way receives no forced write-back.
- R5: At most one request is outstanding. `wb_req_o` and `wb_line_o` hold steady until `wb_ack_i`, and the acknowledge clears both flags of the requested line.
- R6: A store to a line whose force flag is set leaves the force flag at 1, so the line is written back on the next walk.
- R7: `cs_grant_o` is 1 exactly when `cs_req_i` is 1 and no request is outstanding. While `cs_req_i` is 1 no new request starts.
- R8: A walk starts only when at least `period_i` cycles have passed since the previous walk started and that walk has finished. Walks visit lines 0 to `LINES-1` in ascending order, so requests within one walk come out in ascending index order.
- R9: A line that is stored once and then left alone, with requests acknowledged, is written back within two walks, and afterwards both of its flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PERIOD_W | Minimum number of cycles between walk starts |
| upd_valid_i | input | 1 | Store to a line this cycle |
| upd_line_i | input | IDX_W | Index of the stored line |
| evict_valid_i | input | 1 | Eviction of a line this cycle |
| evict_line_i | input | IDX_W | Index of the evicted line |
| wb_req_o | output | 1 | Forced write-back request |
| wb_line_o | output | IDX_W | Line index of the request |
| wb_ack_i | input | 1 | Write-back finished |
| cs_req_i | input | 1 | Context switch wants to proceed |
| cs_grant_o | output | 1 | Context switch may proceed |
| dirty_o | output | LINES | Dirty flag of each line |
| fwb_o | output | LINES | Force flag of each line |

## Verification
The assertions assume that `wb_ack_i` is only raised while `wb_req_o` is high, and that a store and an eviction never name the same line in the same cycle. The bench's acknowledge responder only answers a visible request. Its random traffic picks the store and eviction targets so that they never coincide, and it drives every input half a cycle away from the sampling edge. The directed cases place stores just after the last line has been written back, so the order and timing of each walk are known without looking inside the block.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_SCAN = 2'd1,
    SW_WAIT = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/fwb_period_timer.sv
module fwb_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                restart_i,
  output logic                expired_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  assign expired_o = (cnt_q >= period_i);

  always_comb begin
    cnt_en = restart_i || !expired_o;
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fwb_line_flags.sv
module fwb_line_flags #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_line_i,
  input  logic             evict_valid_i,
  input  logic [IDX_W-1:0] evict_line_i,
  input  logic             done_valid_i,
  input  logic [IDX_W-1:0] done_line_i,
  input  logic             mark_valid_i,
  input  logic [IDX_W-1:0] mark_line_i,
  output logic [LINES-1:0] dirty_o,
  output logic [LINES-1:0] fwb_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic hit_upd, hit_clr, hit_mark, en;
    logic dirty_q, dirty_d, fwb_q, fwb_d;

    always_comb begin
      hit_upd  = upd_valid_i && (upd_line_i == IDX_W'(g));
      hit_clr  = (evict_valid_i && (evict_line_i == IDX_W'(g))) ||
                 (done_valid_i  && (done_line_i  == IDX_W'(g)));
      hit_mark = mark_valid_i && (mark_line_i == IDX_W'(g));
      en       = hit_upd || hit_clr || hit_mark;
      // a store keeps new data dirty; clearing dirty always drops the force mark
      dirty_d  = hit_upd ? 1'b1 : (hit_clr ? 1'b0 : dirty_q);
      fwb_d    = hit_clr ? 1'b0 : (hit_mark ? 1'b1 : fwb_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dirty_q <= 1'b0;
        fwb_q   <= 1'b0;
      end else if (en) begin
        dirty_q <= dirty_d;
        fwb_q   <= fwb_d;
      end
    end

    assign dirty_o[g] = dirty_q;
    assign fwb_o[g]   = fwb_q;
  end
endmodule

// File: rtl/fwb_sweep_fsm.sv
module fwb_sweep_fsm
  import fwb_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expired_i,
  input  logic             hold_i,
  input  logic             ack_i,
  input  logic [LINES-1:0] dirty_i,
  input  logic [LINES-1:0] fwb_i,
  output logic             restart_o,
  output logic             mark_valid_o,
  output logic             done_valid_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

  sweep_state_t     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             advance, cur_dirty, cur_fwb;

  assign cur_dirty = dirty_i[idx_q];
  assign cur_fwb   = fwb_i[idx_q];

  always_comb begin
    state_d      = state_q;
    idx_d        = idx_q;
    restart_o    = 1'b0;
    mark_valid_o = 1'b0;
    done_valid_o = 1'b0;
    advance      = 1'b0;
    unique case (state_q)
      SW_IDLE: if (expired_i) begin
        restart_o = 1'b1;
        state_d   = SW_SCAN;
        idx_d     = '0;
      end
      SW_SCAN: begin
        if (cur_dirty && cur_fwb) begin
          if (!hold_i) state_d = SW_WAIT;
        end else begin
          mark_valid_o = cur_dirty;
          advance      = 1'b1;
        end
      end
      SW_WAIT: if (ack_i) begin
        done_valid_o = 1'b1;
        advance      = 1'b1;
      end
      default: state_d = SW_IDLE;
    endcase
    if (advance) begin
      if (idx_q == LAST) state_d = SW_IDLE;
      else begin
        state_d = SW_SCAN;
        idx_d   = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign req_o = (state_q == SW_WAIT);
  assign idx_o = idx_q;
endmodule

// File: rtl/fwb_scanner.sv
module fwb_scanner #(
  parameter int LINES    = 8,
  parameter int PERIOD_W = 16,
  parameter int IDX_W    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                upd_valid_i,
  input  logic [IDX_W-1:0]    upd_line_i,
  input  logic                evict_valid_i,
  input  logic [IDX_W-1:0]    evict_line_i,
  output logic                wb_req_o,
  output logic [IDX_W-1:0]    wb_line_o,
  input  logic                wb_ack_i,
  input  logic                cs_req_i,
  output logic                cs_grant_o,
  output logic [LINES-1:0]    dirty_o,
  output logic [LINES-1:0]    fwb_o
);
  logic expired, restart, mark_valid, done_valid;

  fwb_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .restart_i(restart), .expired_o(expired)
  );

  fwb_sweep_fsm #(.LINES(LINES), .IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .expired_i(expired), .hold_i(cs_req_i),
    .ack_i(wb_ack_i), .dirty_i(dirty_o), .fwb_i(fwb_o),
    .restart_o(restart), .mark_valid_o(mark_valid), .done_valid_o(done_valid),
    .req_o(wb_req_o), .idx_o(wb_line_o)
  );

  fwb_line_flags #(.LINES(LINES), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .upd_valid_i(upd_valid_i), .upd_line_i(upd_line_i),
    .evict_valid_i(evict_valid_i), .evict_line_i(evict_line_i),
    .done_valid_i(done_valid), .done_line_i(wb_line_o),
    .mark_valid_i(mark_valid), .mark_line_i(wb_line_o),
    .dirty_o(dirty_o), .fwb_o(fwb_o)
  );

  assign cs_grant_o = cs_req_i && !wb_req_o;
endmodule

// File: rtl/fwb_scanner_chk.sv
module fwb_scanner_chk #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wb_req_o,
  input logic [IDX_W-1:0] wb_line_o,
  input logic             wb_ack_i,
  input logic             cs_req_i,
  input logic             cs_grant_o,
  input logic [LINES-1:0] dirty_o,
  input logic [LINES-1:0] fwb_o
);
  logic [LINES-1:0] fwb_prev, dirty_prev;
  logic             cs_prev, req_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwb_prev   <= '0;
      dirty_prev <= '0;
      cs_prev    <= 1'b0;
      req_prev   <= 1'b0;
    end else begin
      fwb_prev   <= fwb_o;
      dirty_prev <= dirty_o;
      cs_prev    <= cs_req_i;
      req_prev   <= wb_req_o;
    end
  end

  // R4: a force mark never outlives its dirty flag
  a_r4_force_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (fwb_o & ~dirty_o) == '0);

  // R5: request held steady until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_line_o)));

  // R5: acknowledge drops the force mark of the served line
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && wb_ack_i) |=> !fwb_o[$past(wb_line_o)]);

  // R3: a new request targets a line that was marked and dirty
  a_r3_req_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !req_prev) |-> (fwb_prev[wb_line_o] && dirty_prev[wb_line_o]));

  // R7: grant only without an outstanding request, no request starts under hold
  a_r7_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_grant_o |-> !wb_req_o);
  a_r7_no_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req_o && !req_prev) |-> !cs_prev);
endmodule

bind fwb_scanner fwb_scanner_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_req_o(wb_req_o), .wb_line_o(wb_line_o),
  .wb_ack_i(wb_ack_i), .cs_req_i(cs_req_i), .cs_grant_o(cs_grant_o),
  .dirty_o(dirty_o), .fwb_o(fwb_o)
);

// File: tb/fwb_scanner_test.sv
`timescale 1ns/1ps
module fwb_scanner_test;
  localparam int LINES = 8;
  localparam int PW    = 16;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] period_i = 16'd20;
  logic          upd_valid_i = 1'b0, evict_valid_i = 1'b0, wb_ack_i = 1'b0, cs_req_i = 1'b0;
  logic [IW-1:0] upd_line_i = '0, evict_line_i = '0;
  logic          wb_req_o, cs_grant_o;
  logic [IW-1:0] wb_line_o;
  logic [LINES-1:0] dirty_o, fwb_o;

  int checks = 0, errors = 0, cycles = 0;
  int req_count [LINES];
  int rises_under_cs = 0, bad_rise = 0;
  bit auto_ack = 0, prev_req = 0, prev_cs = 0, finished = 0;
  logic [LINES-1:0] prev_fwb = '0, prev_dirty = '0;
  int ack_wait = 0;

  fwb_scanner #(.LINES(LINES), .PERIOD_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i),
    .upd_valid_i(upd_valid_i), .upd_line_i(upd_line_i),
    .evict_valid_i(evict_valid_i), .evict_line_i(evict_line_i),
    .wb_req_o(wb_req_o), .wb_line_o(wb_line_o), .wb_ack_i(wb_ack_i),
    .cs_req_i(cs_req_i), .cs_grant_o(cs_grant_o), .dirty_o(dirty_o), .fwb_o(fwb_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gap_max(input int p);
    return 2 * p + 2 * LINES + 8;
  endfunction

  // monitor and auto responder, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (wb_req_o && !prev_req) begin
        req_count[wb_line_o]++;
        if (!(prev_fwb[wb_line_o] && prev_dirty[wb_line_o])) bad_rise++;
        if (prev_cs) rises_under_cs++;
      end
      if (auto_ack) begin
        if (wb_ack_i) wb_ack_i = 1'b0;
        else if (wb_req_o) begin
          if (ack_wait == 0) begin wb_ack_i = 1'b1; ack_wait = $urandom_range(0, 3); end
          else ack_wait--;
        end
      end
    end
    prev_req = wb_req_o; prev_cs = cs_req_i; prev_fwb = fwb_o; prev_dirty = dirty_o;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic store(input int l);
    @(negedge clk); upd_valid_i = 1'b1; upd_line_i = IW'(l);
    @(negedge clk); upd_valid_i = 1'b0;
  endtask

  task automatic wait_flag(input int l);
    for (int i = 0; i < 1000 && !fwb_o[l]; i++) @(negedge clk);
  endtask

  task automatic wait_req();
    for (int i = 0; i < 1000 && !wb_req_o; i++) @(negedge clk);
  endtask

  task automatic ack();
    wb_ack_i = 1'b1; @(negedge clk); wb_ack_i = 1'b0;
  endtask

  int t1, t2, ord [3];

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < LINES; i++) req_count[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dirty_o == 0 && fwb_o == 0, "R1 flags", int'({dirty_o, fwb_o}), 0);
    chk(!wb_req_o && !cs_grant_o, "R1 req/grant", int'({wb_req_o, cs_grant_o}), 0);
    rst_n = 1'b1;

    // R2 store, mark without write-back
    store(3);
    chk(dirty_o[3] && !fwb_o[3], "R2 dirty set", int'({dirty_o[3], fwb_o[3]}), 2);
    wait_flag(3);
    chk(fwb_o[3] && req_count[3] == 0, "R2 mark no wb", req_count[3], 0);
    // R3 second walk requests it
    wait_req();
    chk(wb_req_o && wb_line_o == 3, "R3 req line", int'(wb_line_o), 3);
    repeat (5) @(negedge clk);
    chk(wb_req_o && wb_line_o == 3, "R5 held", int'({wb_req_o, wb_line_o}), 11);
    ack();
    chk(!dirty_o[3] && !fwb_o[3] && !wb_req_o, "R5 ack clears",
        int'({dirty_o[3], fwb_o[3], wb_req_o}), 0);

    // R4 eviction cancels
    req_count[5] = 0;
    store(5); wait_flag(5);
    @(negedge clk); evict_valid_i = 1'b1; evict_line_i = 3'd5;
    @(negedge clk); evict_valid_i = 1'b0;
    chk(!dirty_o[5] && !fwb_o[5], "R4 evict clears", int'({dirty_o[5], fwb_o[5]}), 0);
    repeat (3 * (20 + LINES + 4)) @(negedge clk);
    chk(req_count[5] == 0, "R4 no wb", req_count[5], 0);

    // R6 store keeps force
    store(2); wait_flag(2);
    store(2);
    chk(fwb_o[2] && dirty_o[2], "R6 force kept", int'({dirty_o[2], fwb_o[2]}), 3);
    wait_req();
    chk(wb_line_o == 2, "R6 next walk", int'(wb_line_o), 2);
    ack();

    // R7 context switch hold
    store(4); wait_req();
    cs_req_i = 1'b1; @(negedge clk);
    chk(!cs_grant_o, "R7 grant blocked", int'(cs_grant_o), 0);
    ack();
    chk(cs_grant_o && !wb_req_o, "R7 grant after ack", int'(cs_grant_o), 1);
    store(5);
    repeat (3 * (20 + LINES + 4)) @(negedge clk);
    chk(rises_under_cs == 0 && !wb_req_o && fwb_o[5], "R7 no start held", rises_under_cs, 0);
    cs_req_i = 1'b0;
    wait_req();
    chk(wb_line_o == 5, "R7 resumes", int'(wb_line_o), 5);
    ack();

    // R8 ascending order: stores right after the last line is served
    period_i = 16'd60;
    store(7); wait_req();
    while (wb_line_o != 7) begin ack(); wait_req(); end
    ack();
    store(6); store(1); store(4);
    for (int k = 0; k < 3; k++) begin wait_req(); ord[k] = int'(wb_line_o); ack(); end
    chk(ord[0] == 1 && ord[1] == 4 && ord[2] == 6, "R8 order",
        ord[0] * 100 + ord[1] * 10 + ord[2], 146);

    // R8 period spacing: line 0 restored right after each write-back
    store(0); wait_req();
    while (wb_line_o != 0) begin ack(); wait_req(); end
    t1 = cycles; ack(); store(0);
    wait_req(); t2 = cycles;
    chk(wb_line_o == 0 && (t2 - t1) >= 2 * 60 && (t2 - t1) <= gap_max(60),
        "R8 spacing", t2 - t1, 2 * 60);
    ack();

    // R9 random traffic then drain
    period_i = 16'd25;
    auto_ack = 1;
    bad_rise = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      upd_valid_i = ($urandom_range(0, 3) == 0);
      upd_line_i = IW'($urandom_range(0, LINES - 1));
      evict_valid_i = ($urandom_range(0, 15) == 0);
      evict_line_i = IW'($urandom_range(0, LINES - 1));
      if (evict_line_i == upd_line_i) evict_valid_i = 1'b0;
      cs_req_i = ($urandom_range(0, 31) == 0);
    end
    @(negedge clk);
    upd_valid_i = 1'b0; evict_valid_i = 1'b0; cs_req_i = 1'b0;
    repeat (2 * (25 + 1) + LINES * 6 + 60) @(negedge clk);
    chk(dirty_o == 0 && fwb_o == 0, "R9 drained", int'({dirty_o, fwb_o}), 0);
    chk(bad_rise == 0, "R3 random targets", bad_rise, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule